// File: doc/BRIEF.md
# Timer Count-Source and Edge Selector

This block sits in front of a 16-bit timer and decides when the timer counts. It holds an 8-bit mode register that software can write and read back. The register chooses one of four count sources: a fast prescaler tap at the system clock divided by 2, a slow tap at the system clock divided by 16, an external watch-timer tick, or a detected edge on external timer input pin 0. The block turns the selected source into a count-enable strobe that is one clock cycle wide.

The block also watches two external timer input pins. Each pin passes through a synchroniser and then an edge detector. Each detector can report falling edges, rising edges or both, and it produces a one-cycle valid-edge strobe for the timer's clear/start and capture logic. The block finds two kinds of configuration error and reports them on a single flag:
- a prohibited edge code in the mode register;
- a request to use pin 0 for clear/start or capture while pin 0 is also the count source.

The edge history of each detector starts low at reset. A pin that is already high when the timer is first started therefore reports a rising edge at once. After the timer has run once, the history follows the pin while the timer is halted, so a later restart reports no such edge.

Top module: `tcs_top`

## Requirements
- R1: After reset, rd_data reads 0x00, and count_en, edge_strb, pin0_ctrl_strb and cfg_err are all low.
- R2: rd_data bits [3:2] always read 0. The edge fields (bits [7:6] for pin 1, bits [5:4] for pin 0) take the written value on any write, even while run is high.
- R3: A write while run is high leaves the clock-select field, bits [1:0], unchanged. A write while run is low updates it.
- R4: With clock select 00 and run high, count_en pulses on every second cycle, starting with the second cycle after run rises.
- R5: With clock select 01 and run high, count_en pulses once every 16 cycles, first on the 16th cycle after run rises. The prescaler restarts from zero every time run is low.
- R6: With clock select 10 and run high, count_en equals watch_tick in the same cycle.
- R7: Edge codes for each pin field are 00 = falling, 01 = rising, 11 = both. A matching pin transition gives a one-cycle pulse on that pin's edge_strb bit two cycles after the pin changes, but only while run is high.
- R8: Writing edge code 10 to either pin field suppresses that pin's strobes and sets cfg_err. cfg_err stays set until a write places legal codes in both fields.
- R9: With clock select 11, count_en pulses in the same cycle as edge_strb[0].
- R10: pin0_ctrl_strb follows edge_strb[0] when pin0_ctrl_req is high, unless clock select is 11. In that case pin0_ctrl_strb stays low and cfg_err is high.
- R11: If a pin is high when run first rises after reset, and its edge code is rising or both, the pin reports a rising strobe in that first run cycle. A later restart after a halt does not produce this strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer enabled (high) or halted (low) |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| rd_data | output | 8 | Mode register read value |
| watch_tick | input | 1 | Watch-timer tick, synchronous and one cycle wide |
| tin | input | 2 | External timer input pins, asynchronous |
| pin0_ctrl_req | input | 1 | Timer wants pin 0 edges for clear/start or capture |
| count_en | output | 1 | One-cycle count-enable strobe |
| edge_strb | output | 2 | One-cycle valid-edge strobe per pin |
| pin0_ctrl_strb | output | 1 | Pin 0 edge passed on to clear/start or capture |
| cfg_err | output | 1 | Configuration error flag |

## Verification
The hardest case to reach is the rising edge that appears on the first start after reset. The stimulus holds pin 0 high through reset, selects rising edges while the timer is halted, and only then raises run. The strobe is expected in that very first run cycle. The bench then halts the timer, pulses the pin low and high again while halted, and restarts. It expects no edge on the restart, so the difference between the first enable and later ones shows at the ports. The slow-tap check also depends on this halt, because it verifies that the prescaler restarts from zero.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int MODE_W = 8;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BAD  = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   typedef enum logic [1:0] {
      SRC_DIV_FAST = 2'b00,
      SRC_DIV_SLOW = 2'b01,
      SRC_WATCH    = 2'b10,
      SRC_PIN0     = 2'b11
   } clk_src_e;

   // Field positions are fixed because software decodes them.
   typedef struct packed {
      edge_mode_e edge1;
      edge_mode_e edge0;
      logic [1:0] rsvd;
      clk_src_e   src;
   } mode_reg_t;

endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tcs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tcs_edge.sv
module tcs_edge
   import tcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       lvl,
   input  edge_mode_e mode,
   output logic       strb
);
   // History starts low; it only begins to track the pin after the first run,
   // so a pin high at power-up reads as a rise on the very first enable.
   logic prev;
   logic armed;
   logic rise, fall, hit;

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      unique case (mode)
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   assign strb = run & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (run)          armed <= 1'b1;
         if (run || armed) prev  <= lvl;
      end
   end
endmodule

// File: rtl/tcs_prescale.sv
module tcs_prescale #(
   parameter int PRE_W     = 4,
   parameter int FAST_LOG2 = 1,
   parameter int SLOW_LOG2 = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   output logic [1:0] taps
);
   if (FAST_LOG2 < 1 || FAST_LOG2 >= SLOW_LOG2 || SLOW_LOG2 > PRE_W) begin : g_bad_taps
      $error("tcs_prescale: need 1 <= FAST_LOG2 < SLOW_LOG2 <= PRE_W");
   end

   logic [PRE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   for (genvar t = 0; t < 2; t++) begin : g_tap
      localparam int L = (t == 0) ? FAST_LOG2 : SLOW_LOG2;
      assign taps[t] = run & (&cnt[L-1:0]);
   end
endmodule

// File: rtl/tcs_modereg.sv
module tcs_modereg
   import tcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output mode_reg_t         mode,
   output logic              prohib_err
);
   mode_reg_t   nxt;
   logic        bad_code;

   always_comb begin
      nxt       = mode;
      nxt.edge1 = edge_mode_e'(wr_data[7:6]);
      nxt.edge0 = edge_mode_e'(wr_data[5:4]);
      nxt.rsvd  = 2'b00;
      if (!run) nxt.src = clk_src_e'(wr_data[1:0]);
   end

   assign bad_code = (wr_data[7:6] == EDGE_BAD) || (wr_data[5:4] == EDGE_BAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= '0;
         prohib_err <= 1'b0;
      end else if (wr_en) begin
         mode       <= nxt;
         prohib_err <= bad_code;
      end
   end
endmodule

// File: rtl/tcs_top.sv
module tcs_top
   import tcs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_W       = 4,
   parameter int FAST_LOG2   = 1,
   parameter int SLOW_LOG2   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       watch_tick,
   input  logic [1:0] tin,
   input  logic       pin0_ctrl_req,
   output logic       count_en,
   output logic [1:0] edge_strb,
   output logic       pin0_ctrl_strb,
   output logic       cfg_err
);
   localparam int NPINS = 2;

   mode_reg_t        mode;
   logic             prohib_err;
   logic [NPINS-1:0] tin_s;
   logic [1:0]       taps;
   edge_mode_e       pin_mode [NPINS];

   assign pin_mode[0] = mode.edge0;
   assign pin_mode[1] = mode.edge1;

   tcs_modereg u_reg (
      .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_data(wr_data),
      .mode(mode), .prohib_err(prohib_err)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      tcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(tin[p]), .q(tin_s[p])
      );
      tcs_edge u_edge (
         .clk(clk), .rst_n(rst_n), .run(run), .lvl(tin_s[p]),
         .mode(pin_mode[p]), .strb(edge_strb[p])
      );
   end

   tcs_prescale #(.PRE_W(PRE_W), .FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .taps(taps)
   );

   always_comb begin
      unique case (mode.src)
         SRC_DIV_FAST: count_en = taps[0];
         SRC_DIV_SLOW: count_en = taps[1];
         SRC_WATCH:    count_en = run & watch_tick;
         default:      count_en = edge_strb[0];
      endcase
   end

   logic pin0_is_clk;
   assign pin0_is_clk    = (mode.src == SRC_PIN0);
   assign pin0_ctrl_strb = pin0_ctrl_req & edge_strb[0] & ~pin0_is_clk;
   assign cfg_err        = prohib_err | (pin0_ctrl_req & pin0_is_clk);
   assign rd_data        = mode;
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic       wr_en,
   input logic [7:0] rd_data,
   input logic       watch_tick,
   input logic       pin0_ctrl_req,
   input logic       count_en,
   input logic [1:0] edge_strb,
   input logic       pin0_ctrl_strb,
   input logic       cfg_err
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[3:2] == 2'b00); // R2
   AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wr_en) |=> rd_data[1:0] == $past(rd_data[1:0])); // R3
   AST_FAST_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rd_data[1:0] == 2'b00 && count_en) |=> !count_en); // R4
   AST_WATCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rd_data[1:0] == 2'b10) |-> count_en == watch_tick); // R6
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!count_en && edge_strb == 2'b00)); // R7
   AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[5:4] == 2'b10) |-> (!edge_strb[0] && cfg_err)); // R8
   AST_PIN0_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[1:0] == 2'b11 && pin0_ctrl_req) |-> (cfg_err && !pin0_ctrl_strb)); // R10
endmodule

bind tcs_top tcs_checker u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .rd_data(rd_data),
   .watch_tick(watch_tick), .pin0_ctrl_req(pin0_ctrl_req), .count_en(count_en),
   .edge_strb(edge_strb), .pin0_ctrl_strb(pin0_ctrl_strb), .cfg_err(cfg_err)
);

// File: tb/tcs_top_test.sv
module tcs_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       watch_tick = 1'b0;
   logic [1:0] tin = 2'b01;
   logic       pin0_ctrl_req = 1'b0;
   logic       count_en;
   logic [1:0] edge_strb;
   logic       pin0_ctrl_strb;
   logic       cfg_err;

   tcs_top uut (
      .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .watch_tick(watch_tick), .tin(tin),
      .pin0_ctrl_req(pin0_ctrl_req), .count_en(count_en), .edge_strb(edge_strb),
      .pin0_ctrl_strb(pin0_ctrl_strb), .cfg_err(cfg_err)
   );

   always #10 clk = ~clk;

   // kinds: 0 rd_data, 1 count_en, 2 edge_strb, 3 pin0_ctrl_strb, 4 cfg_err
   typedef struct {
      int         kind;
      logic [7:0] val;
      string      req;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   logic [7:0] act;

   task automatic want(input int kind, input logic [7:0] v, input string req);
      exp_t e;
      e.kind = kind;
      e.val  = v;
      e.req  = req;
      q.push_back(e);
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      wr_en      = 1'b0;
      watch_tick = 1'b0;
   endtask

   always @(negedge clk) begin
      while (q.size() > 0) begin
         cur = q.pop_front();
         case (cur.kind)
            0:       act = rd_data;
            1:       act = {7'b0, count_en};
            2:       act = {6'b0, edge_strb};
            3:       act = {7'b0, pin0_ctrl_strb};
            default: act = {7'b0, cfg_err};
         endcase
         n_cmp++;
         if (act !== cur.val) begin
            n_bad++;
            $display("FAIL %s kind %0d actual %h expected %h at %0t",
                     cur.req, cur.kind, act, cur.val, $time);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state (pin 0 held high through reset)
      tick(); want(0, 8'h00, "R1"); want(1, 0, "R1"); want(2, 0, "R1");
      want(3, 0, "R1"); want(4, 0, "R1");

      // R2 reserved bits read zero
      tick(); wr_en = 1; wr_data = 8'h1C;
      tick(); want(0, 8'h10, "R2");
      for (int i = 0; i < 3; i++) begin tick(); want(2, 0, "R7"); end

      // R11 first enable with pin high; R4 fast tap
      tick(); run = 1; want(2, 8'h01, "R11"); want(1, 0, "R4");
      tick(); want(2, 0, "R11"); want(1, 1, "R4");
      tick(); want(1, 0, "R4"); wr_en = 1; wr_data = 8'h11;
      tick(); want(1, 1, "R4"); want(0, 8'h10, "R3");

      // halt; source write accepted; pin pulses while halted
      tick(); run = 0; want(1, 0, "R5");
      tick(); wr_en = 1; wr_data = 8'h11;
      tick(); want(0, 8'h11, "R3"); tin = 2'b00;
      for (int i = 0; i < 3; i++) tick();
      tin = 2'b01;
      for (int i = 0; i < 3; i++) tick();

      // R5 slow tap after restart; R11 no edge on re-enable
      for (int i = 0; i < 20; i++) begin
         tick(); run = 1;
         want(1, (i == 15) ? 8'h01 : 8'h00, "R5");
         if (i == 0) want(2, 0, "R11");
      end

      // R6 watch tick pass-through
      tick(); run = 0;
      tick(); wr_en = 1; wr_data = 8'h12;
      tick(); run = 1; watch_tick = 1; want(1, 1, "R6");
      tick(); want(1, 0, "R6");
      tick(); watch_tick = 1; want(1, 1, "R6");
      tick(); run = 0; watch_tick = 1; want(1, 0, "R6");

      // R7 pin1 both edges, pin0 falling
      tick(); wr_en = 1; wr_data = 8'hC0;
      tick(); run = 1; want(0, 8'hC0, "R2");
      tick(); tin = 2'b00; want(2, 0, "R7");
      tick(); want(2, 0, "R7");
      tick(); want(2, 8'h01, "R7");
      tick(); want(2, 0, "R7");
      tick(); tin = 2'b10;
      tick();
      tick(); want(2, 8'h02, "R7");
      tick(); want(2, 0, "R7");
      tick(); tin = 2'b00;
      tick();
      tick(); want(2, 8'h02, "R7");

      // R8 prohibited code
      tick(); wr_en = 1; wr_data = 8'h20;
      tick(); want(4, 1, "R8"); tin = 2'b01;
      tick();
      tick(); want(2, 0, "R8"); want(4, 1, "R8");
      tick(); wr_en = 1; wr_data = 8'h10;
      tick(); want(4, 0, "R8"); want(0, 8'h10, "R8");

      // R9 pin 0 as count source
      tick(); run = 0; tin = 2'b00;
      tick(); wr_en = 1; wr_data = 8'h13;
      tick();
      tick();
      tick(); run = 1; want(0, 8'h13, "R9"); want(1, 0, "R9");
      tick(); tin = 2'b01;
      tick();
      tick(); want(1, 1, "R9"); want(2, 8'h01, "R9"); want(4, 0, "R10");
      tick(); want(1, 0, "R9");

      // R10 conflict: pin 0 is clock and control requested
      tick(); pin0_ctrl_req = 1; tin = 2'b00; want(4, 1, "R10");
      tick();
      tick(); tin = 2'b01;
      tick();
      tick(); want(2, 8'h01, "R10"); want(3, 0, "R10"); want(4, 1, "R10");

      // R10 no conflict: control strobe passes
      tick(); run = 0; tin = 2'b00;
      tick(); wr_en = 1; wr_data = 8'h10;
      tick(); run = 1; want(4, 0, "R10");
      tick(); tin = 2'b01;
      tick();
      tick(); want(3, 1, "R10"); want(2, 8'h01, "R10");
      tick(); want(3, 0, "R10");

      tick();
      tick();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule